// File: doc/BRIEF.md
# Fly-by DMA request controller

This block serves three request channels from I/O cards on a shared, ISA-style system bus. A card raises its request line. The controller then asks the host for the bus through a hold request and waits for the hold grant. It then drives the memory address onto the bus itself and answers the winning card on that card's own acknowledge line.

Transfers are fly-by. In the same cycles the controller asserts a memory strobe and an I/O strobe, so the byte moves straight from memory to the card, or from the card to memory, without passing through the controller. A per-channel direction bit picks which pair of strobes is used.

The host sets up each channel through a small write port. It loads a 16-bit address that steps up after every byte, a 16-bit count that steps down, and a control word. When a channel's count passes zero, the channel raises its terminal-count flag and disables itself.

Top module: `dma_flyby_ctrl`

## Requirements
- R1: After reset, `dack`, `hold_req`, `addr_oe`, all four strobes and `tc` are low. Every channel is disabled, so requests are ignored until the host enables a channel.
- R2: A host write with `prog_we` high loads one field of channel `prog_ch`, chosen by `prog_field`. Code 0 loads the address, code 1 loads the count and code 2 loads the control word. In the control word, bit 0 is enable and bit 1 is direction.
- R3: A pending request on an enabled channel raises `hold_req` on the next cycle. `dack` stays low until `hold_gnt` is seen high with the request still present. The first `dack` cycle is the cycle after that edge.
- R4: When several enabled channels request at once, the lowest-numbered one is served.
- R5: `dack` is one-hot or zero. The granted channel's acknowledge stays high for exactly XFER_CYC (default 4) consecutive cycles.
- R6: With direction 0, `mem_rd` and `io_wr` are high together during the window. With direction 1, `io_rd` and `mem_wr` are high together. Outside the window all four strobes are low.
- R7: During the window, `mem_addr` holds the channel's current address and `addr_oe` is high. After each transfer the address goes up by one, wrapping at 16 bits, and the count goes down by one.
- R8: A transfer that starts with a count of 0 sets that channel's `tc` bit and clears its enable once the window ends. Later requests on that channel are ignored. Writing the control word with enable set clears `tc`.
- R9: If a request drops before its acknowledge, the controller releases `hold_req`, gives no acknowledge and leaves the channel's address unchanged.
- R10: After the window, `hold_req` stays high until the served channel's request goes low. It is low on the cycle after that.
- R11: A request on a disabled channel never raises `hold_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq | input | NCH | Per-channel transfer request from the I/O cards |
| dack | output | NCH | Per-channel acknowledge, high for the transfer window |
| hold_req | output | 1 | Bus hold request to the host |
| hold_gnt | input | 1 | Bus hold grant from the host |
| mem_addr | output | ADDR_W | Memory address driven during a transfer |
| addr_oe | output | 1 | Address drive enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| tc | output | NCH | Per-channel terminal-count flags |
| prog_we | input | 1 | Host register write strobe |
| prog_ch | input | IDX_W | Channel selected for the write |
| prog_field | input | 2 | Field code: 0 address, 1 count, 2 control |
| prog_data | input | PROG_W | Write data |

## Verification
On every cycle the assertions check the following:
- the one-hot acknowledge;
- the exact length of the acknowledge window;
- that the strobes always come in matched read/write pairs tied to the window;
- that an acknowledge only follows a granted hold and a live request;
- that the address stays steady inside a window.

Some behaviours only the bench scenarios can show:
- the fixed priority order;
- the address increment and its wrap;
- the point at which the count reaches terminal count and disables a channel;
- that an abandoned request leaves the address untouched;
- that clearing the flag restarts a channel.

// File: rtl/dma_fly_pkg.sv
package dma_fly_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_XFER    = 2'd2,
        ST_RELEASE = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        FLD_ADDR  = 2'd0,
        FLD_COUNT = 2'd1,
        FLD_CTRL  = 2'd2
    } prog_field_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_DIR_BIT = 1;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } strobe_t;

    // direction 0: memory -> card, direction 1: card -> memory
    function automatic strobe_t strobes_for(input logic active, input logic dir);
        strobe_t s;
        s.mem_rd = active & ~dir;
        s.io_wr  = active & ~dir;
        s.io_rd  = active &  dir;
        s.mem_wr = active &  dir;
        return s;
    endfunction

endpackage

// File: rtl/dma_fly_arb.sv
module dma_fly_arb #(
    parameter int NCH   = 3,
    parameter int IDX_W = 2
) (
    input  logic [NCH-1:0]   req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // lowest index wins: scan from the top so the last hit is the lowest
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_fly_chan.sv
module dma_fly_chan
    import dma_fly_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              en,
    output logic              dir,
    output logic              tc
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            cnt  <= '0;
            en   <= 1'b0;
            dir  <= 1'b0;
            tc   <= 1'b0;
        end else begin
            if (step) begin
                addr <= addr + 1'b1;
                cnt  <= cnt - 1'b1;
                if (cnt == '0) begin
                    tc <= 1'b1;
                    en <= 1'b0;
                end
            end
            if (wr_addr) addr <= wdata[ADDR_W-1:0];
            if (wr_cnt)  cnt  <= wdata[CNT_W-1:0];
            if (wr_ctl) begin
                en  <= wdata[CTRL_EN_BIT];
                dir <= wdata[CTRL_DIR_BIT];
                if (wdata[CTRL_EN_BIT]) tc <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma_fly_seq.sv
module dma_fly_seq
    import dma_fly_pkg::*;
#(
    parameter int NCH      = 3,
    parameter int IDX_W    = 2,
    parameter int XFER_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   dreq,
    input  logic [NCH-1:0]   en_mask,
    input  logic             hold_gnt,
    output logic             hold_req,
    output logic             active,
    output logic [IDX_W-1:0] sel,
    output logic             step
);
    localparam int BEAT_W = $clog2(XFER_CYC + 1);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(XFER_CYC - 1);

    seq_state_e        state;
    logic [BEAT_W-1:0] beat;
    logic              arb_any;
    logic [IDX_W-1:0]  arb_idx;
    logic              sel_req;
    logic              sel_en;

    dma_fly_arb #(.NCH(NCH), .IDX_W(IDX_W)) u_arb (
        .req (dreq & en_mask),
        .any (arb_any),
        .idx (arb_idx)
    );

    always_comb begin
        sel_req = 1'b0;
        sel_en  = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (sel == IDX_W'(i)) begin
                sel_req = dreq[i];
                sel_en  = en_mask[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            beat  <= '0;
            sel   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (arb_any) begin
                        sel   <= arb_idx;
                        state <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (!sel_req || !sel_en) begin
                        state <= ST_IDLE;
                    end else if (hold_gnt) begin
                        beat  <= '0;
                        state <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (beat == LAST_BEAT) state <= ST_RELEASE;
                    else                   beat  <= beat + 1'b1;
                end
                ST_RELEASE: begin
                    if (!sel_req) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign hold_req = (state != ST_IDLE);
    assign active   = (state == ST_XFER);
    assign step     = active && (beat == LAST_BEAT);
endmodule

// File: rtl/dma_flyby_ctrl.sv
module dma_flyby_ctrl
    import dma_fly_pkg::*;
#(
    parameter int NCH      = 3,
    parameter int ADDR_W   = 16,
    parameter int CNT_W    = 16,
    parameter int XFER_CYC = 4,
    parameter int IDX_W    = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int PROG_W   = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    dreq,
    output logic [NCH-1:0]    dack,
    output logic              hold_req,
    input  logic              hold_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              addr_oe,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic [NCH-1:0]    tc,
    input  logic              prog_we,
    input  logic [IDX_W-1:0]  prog_ch,
    input  logic [1:0]        prog_field,
    input  logic [PROG_W-1:0] prog_data
);
    logic [ADDR_W-1:0] ch_addr [NCH];
    logic [NCH-1:0]    ch_en;
    logic [NCH-1:0]    ch_dir;
    logic              active;
    logic              step;
    logic [IDX_W-1:0]  sel;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_dir;
    strobe_t           stb;

    dma_fly_seq #(.NCH(NCH), .IDX_W(IDX_W), .XFER_CYC(XFER_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .dreq     (dreq),
        .en_mask  (ch_en),
        .hold_gnt (hold_gnt),
        .hold_req (hold_req),
        .active   (active),
        .sel      (sel),
        .step     (step)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = prog_we && (prog_ch == IDX_W'(g));

        dma_fly_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(PROG_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_addr (hit && (prog_field == FLD_ADDR)),
            .wr_cnt  (hit && (prog_field == FLD_COUNT)),
            .wr_ctl  (hit && (prog_field == FLD_CTRL)),
            .wdata   (prog_data),
            .step    (step && (sel == IDX_W'(g))),
            .addr    (ch_addr[g]),
            .en      (ch_en[g]),
            .dir     (ch_dir[g]),
            .tc      (tc[g])
        );

        assign dack[g] = active && (sel == IDX_W'(g));
    end

    always_comb begin
        sel_addr = '0;
        sel_dir  = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (sel == IDX_W'(i)) begin
                sel_addr = ch_addr[i];
                sel_dir  = ch_dir[i];
            end
        end
    end

    assign stb      = strobes_for(active, sel_dir);
    assign mem_rd   = stb.mem_rd;
    assign mem_wr   = stb.mem_wr;
    assign io_rd    = stb.io_rd;
    assign io_wr    = stb.io_wr;
    assign addr_oe  = active;
    assign mem_addr = active ? sel_addr : '0;
endmodule

// File: rtl/dma_flyby_chk.sv
module dma_flyby_chk #(
    parameter int NCH      = 3,
    parameter int ADDR_W   = 16,
    parameter int XFER_CYC = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    dreq,
    input logic [NCH-1:0]    dack,
    input logic              hold_req,
    input logic              hold_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              io_rd,
    input logic              io_wr
);
    localparam int RUN_W = $clog2(XFER_CYC + 2);

    logic [RUN_W-1:0] run_len;
    logic             ack_any;

    assign ack_any = |dack;

    always_ff @(posedge clk) begin
        if (rst)          run_len <= '0;
        else if (ack_any) run_len <= run_len + 1'b1;
        else              run_len <= '0;
    end

    AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack)); // R5
    AST_WINDOW_MAX: assert property (@(posedge clk) disable iff (rst)
        ack_any |-> (run_len < RUN_W'(XFER_CYC))); // R5
    AST_WINDOW_FULL: assert property (@(posedge clk) disable iff (rst)
        (!ack_any && run_len != '0) |-> (run_len == RUN_W'(XFER_CYC))); // R5
    AST_STROBE_PAIRED: assert property (@(posedge clk) disable iff (rst)
        (mem_rd == io_wr) && (mem_wr == io_rd) && !(mem_rd && mem_wr)); // R6
    AST_STROBE_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) == ack_any); // R6
    AST_ACK_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        (ack_any && !$past(ack_any)) |-> $past(hold_req && hold_gnt)); // R3
    AST_ACK_UNDER_HOLD: assert property (@(posedge clk) disable iff (rst)
        ack_any |-> hold_req); // R3
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (ack_any && !$past(ack_any)) |-> |(dack & $past(dreq))); // R9
    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
        (ack_any && $past(ack_any)) |-> $stable(mem_addr)); // R7
endmodule

bind dma_flyby_ctrl dma_flyby_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .XFER_CYC(XFER_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dreq     (dreq),
    .dack     (dack),
    .hold_req (hold_req),
    .hold_gnt (hold_gnt),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .io_rd    (io_rd),
    .io_wr    (io_wr)
);

// File: tb/sim_dma_flyby_ctrl.sv
module sim_dma_flyby_ctrl;
    localparam int NCH   = 3;
    localparam int XFER  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  dreq = '0;
    logic [2:0]  dack;
    logic        hold_req;
    logic        hold_gnt = 1'b0;
    logic [15:0] mem_addr;
    logic        addr_oe;
    logic        mem_rd, mem_wr, io_rd, io_wr;
    logic [2:0]  tc;
    logic        prog_we = 1'b0;
    logic [1:0]  prog_ch = '0;
    logic [1:0]  prog_field = '0;
    logic [15:0] prog_data = '0;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dma_flyby_ctrl #(.NCH(NCH), .ADDR_W(16), .CNT_W(16), .XFER_CYC(XFER)) u0 (
        .clk(clk), .rst(rst), .dreq(dreq), .dack(dack), .hold_req(hold_req),
        .hold_gnt(hold_gnt), .mem_addr(mem_addr), .addr_oe(addr_oe),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .tc(tc),
        .prog_we(prog_we), .prog_ch(prog_ch), .prog_field(prog_field),
        .prog_data(prog_data)
    );

    // {request mask, expected channel, expected direction, expected address}
    localparam logic [21:0] VECS [7] = '{
        {3'b001, 2'd0, 1'b0, 16'h1000},
        {3'b010, 2'd1, 1'b1, 16'h2000},
        {3'b100, 2'd2, 1'b0, 16'hFFFF},
        {3'b111, 2'd0, 1'b0, 16'h1001},
        {3'b110, 2'd2, 1'b0, 16'h0000},
        {3'b101, 2'd0, 1'b0, 16'h1002},
        {3'b100, 2'd2, 1'b0, 16'h0001}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic prog(input logic [1:0] ch, input logic [1:0] fld, input logic [15:0] d);
        prog_we = 1'b1; prog_ch = ch; prog_field = fld; prog_data = d;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    // called at a negedge; runs one complete granted transfer
    task automatic do_xfer(input logic [2:0] mask, input logic [1:0] ch,
                           input logic d, input logic [15:0] a);
        logic [3:0] exp_stb;
        logic [2:0] exp_ack;
        exp_stb = d ? 4'b0110 : 4'b1001;
        exp_ack = 3'b001 << ch;
        dreq = mask; hold_gnt = 1'b0;
        @(negedge clk);
        chk(hold_req === 1'b1, "R3 hold_req raised", 32'(hold_req), 32'd1);
        chk(dack === 3'b000, "R3 no ack before grant", 32'(dack), 32'd0);
        @(negedge clk);
        chk(dack === 3'b000, "R3 no ack while waiting", 32'(dack), 32'd0);
        hold_gnt = 1'b1;
        for (int k = 0; k < XFER; k++) begin
            @(negedge clk);
            chk(dack === exp_ack, "R4 R5 ack channel", 32'(dack), 32'(exp_ack));
            chk({mem_rd, mem_wr, io_rd, io_wr} === exp_stb, "R6 strobe pair",
                32'({mem_rd, mem_wr, io_rd, io_wr}), 32'(exp_stb));
            chk(mem_addr === a && addr_oe === 1'b1, "R2 R7 address", 32'(mem_addr), 32'(a));
        end
        @(negedge clk);
        chk(dack === 3'b000, "R5 window length", 32'(dack), 32'd0);
        chk({mem_rd, mem_wr, io_rd, io_wr} === 4'b0000, "R6 strobes off",
            32'({mem_rd, mem_wr, io_rd, io_wr}), 32'd0);
        chk(hold_req === 1'b1, "R10 hold kept", 32'(hold_req), 32'd1);
        @(negedge clk);
        chk(hold_req === 1'b1, "R10 hold until request drops", 32'(hold_req), 32'd1);
        dreq[ch] = 1'b0; hold_gnt = 1'b0;
        @(negedge clk);
        chk(hold_req === 1'b0, "R10 hold released", 32'(hold_req), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R3 watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dack === 3'b000 && hold_req === 1'b0 && addr_oe === 1'b0, "R1 reset outputs",
            32'({dack, hold_req, addr_oe}), 32'd0);
        chk({mem_rd, mem_wr, io_rd, io_wr, tc} === 7'b0, "R1 reset strobes and tc",
            32'({mem_rd, mem_wr, io_rd, io_wr, tc}), 32'd0);

        // channels disabled out of reset
        dreq = 3'b111;
        repeat (3) begin
            @(negedge clk);
            chk(hold_req === 1'b0, "R1 R11 disabled after reset", 32'(hold_req), 32'd0);
        end
        dreq = 3'b000;

        prog(2'd0, 2'd0, 16'h1000); prog(2'd0, 2'd1, 16'd2);  prog(2'd0, 2'd2, 16'h0001);
        prog(2'd1, 2'd0, 16'h2000); prog(2'd1, 2'd1, 16'd0);  prog(2'd1, 2'd2, 16'h0003);
        prog(2'd2, 2'd0, 16'hFFFF); prog(2'd2, 2'd1, 16'd5);  prog(2'd2, 2'd2, 16'h0001);

        for (int v = 0; v < 7; v++) begin
            logic [21:0] e;
            e = VECS[v];
            do_xfer(e[21:19], e[18:17], e[16], e[15:0]);
            if (v == 1) chk(tc === 3'b010, "R8 tc after zero count", 32'(tc), 32'h2);
        end
        chk(tc === 3'b011, "R8 tc flags after table", 32'(tc), 32'h3);

        // channel 1 is disabled by terminal count
        dreq = 3'b010;
        repeat (3) begin
            @(negedge clk);
            chk(hold_req === 1'b0, "R8 R11 disabled channel ignored", 32'(hold_req), 32'd0);
        end
        dreq = 3'b000;

        prog(2'd1, 2'd2, 16'h0003);
        chk(tc === 3'b001, "R8 tc cleared on enable", 32'(tc), 32'h1);
        do_xfer(3'b010, 2'd1, 1'b1, 16'h2001);

        // abandoned request: hold raised, request withdrawn before grant
        dreq = 3'b100; hold_gnt = 1'b0;
        @(negedge clk);
        chk(hold_req === 1'b1, "R9 hold raised", 32'(hold_req), 32'd1);
        dreq = 3'b000; hold_gnt = 1'b1;
        @(negedge clk);
        chk(hold_req === 1'b0 && dack === 3'b000, "R9 request dropped",
            32'({hold_req, dack}), 32'd0);
        @(negedge clk);
        chk(dack === 3'b000, "R9 no late ack", 32'(dack), 32'd0);
        hold_gnt = 1'b0;
        do_xfer(3'b100, 2'd2, 1'b0, 16'h0002);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule